// File: doc/BRIEF.md
# Two-Tier Double-Error-Correcting Word Decoder

This block protects a 64-bit data word with a shortened binary BCH code that corrects two bit errors. The code is built over GF(2^7) with the field polynomial x^7 + x^3 + 1. Fourteen check bits come from the roots alpha and alpha^3, and one overall parity bit is added. A combinational encoder port turns a data word into a 79-bit codeword. A decoder port accepts a codeword through a valid/ready handshake and returns the corrected data with status flags.

Decode time depends on the data. A clean word or a word with one flipped bit is finished by the fast tier one cycle after capture. That tier matches the syndrome directly against the code's columns. When the syndrome is non-zero and the overall parity is even, a double error is indicated. The decoder then enters the second tier at once. This tier steps through all 79 positions in turn, removes each candidate's column from the syndrome, and tests whether the remainder is a single column. The search always takes the same number of cycles. Odd-weight patterns that match no column are reported as uncorrectable and are not changed.

Codeword layout: bits [63:0] hold the data. Bits [77:64] hold the check remainder, with bit 64+k the coefficient of x^k. Bit 78 holds the overall parity. Data bit i is the coefficient of x^(14+i).

Top module: `hecc_codec`

## Requirements
- R1: A codeword with no error returns the encoded data with error count 0, the uncorrectable and second-tier flags low, and out_valid_o high in the cycle after the capture edge.
- R2: A single flipped bit at any of the 79 codeword bits, including check bits and the parity bit, returns the original data with error count 1 and the second-tier flag low, one cycle after capture.
- R3: Any two distinct flipped bits return the original data with error count 2 and the second-tier flag high, exactly 80 cycles after capture.
- R4: Three flipped bits are reported with the uncorrectable flag high, error count 3 and the second-tier flag low, one cycle after capture.
- R5: When the uncorrectable flag is high, out_data_o equals bits [63:0] of the received codeword, unchanged.
- R6: A codeword is captured on a rising edge where in_valid_i and in_ready_o are both high. in_ready_o is low from the cycle after capture until the result is presented, and in_valid_i and in_code_i have no effect while it is low.
- R7: out_valid_o is a one-cycle pulse, given exactly once for each captured codeword.
- R8: During and after reset, in_ready_o is high and out_valid_o is low.
- R9: enc_code_o carries enc_data_i unchanged in bits [63:0], and the whole 79-bit codeword has even weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 64 | Data word to encode |
| enc_code_o | output | 79 | Codeword for enc_data_i (combinational) |
| in_valid_i | input | 1 | Codeword offered for decoding |
| in_ready_o | output | 1 | Decoder idle and able to capture |
| in_code_i | input | 79 | Received codeword |
| out_valid_o | output | 1 | Result pulse |
| out_data_o | output | 64 | Corrected (or raw, if uncorrectable) data |
| out_err_count_o | output | 2 | 0, 1 or 2 errors corrected; 3 when uncorrectable |
| out_uncorr_o | output | 1 | Error pattern could not be corrected |
| out_mode2_o | output | 1 | Result came from the second-tier search |

## Verification
The hardest cases to reach are the double errors that involve the overall parity bit. In that case the syndrome looks exactly like a single error, but the parity is even, so the correct answer is found only at the last step of the search. Pairs that mix check-field bits with data bits are also hard, because they test the mapping from polynomial positions to codeword bits in both directions. The bench uses the block's own encoder port to build clean codewords and then applies chosen flip masks. These masks include the pairs (77,78), (0,78) and (63,64), a full sweep of single flips, random pairs and triples, and a stream of junk input that is driven while a search is running.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int GF_M   = 7;
  localparam int GF_N   = (1 << GF_M) - 1;
  localparam logic [GF_M-1:0] GF_POLY = 7'h09;  // x^7 = x^3 + 1
  localparam int DATA_W = 64;
  localparam int CHK_W  = 2 * GF_M;
  localparam int POS_N  = DATA_W + CHK_W;        // polynomial positions
  localparam int CW_W   = POS_N + 1;             // plus overall parity
  localparam int IDX_W  = $clog2(CW_W);
  localparam int CNT_W  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_SEARCH} dec_state_e;

  function automatic logic [GF_M-1:0] gf_step(input logic [GF_M-1:0] v);
    return {v[GF_M-2:0], 1'b0} ^ (v[GF_M-1] ? GF_POLY : '0);
  endfunction

  function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a, input logic [GF_M-1:0] b);
    logic [GF_M-1:0] p, aa;
    p = '0;
    aa = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) p = p ^ aa;
      aa = gf_step(aa);
    end
    return p;
  endfunction

  function automatic logic [GF_M-1:0] gf_pow(input int e);
    logic [GF_M-1:0] v;
    v = 1;
    for (int i = 0; i < e; i++) v = gf_step(v);
    return v;
  endfunction

  // product of minimal polynomials of alpha and alpha^3
  function automatic logic [CHK_W:0] gen_poly();
    logic [CHK_W:0][GF_M-1:0] c;
    logic [CHK_W:0] g;
    logic [GF_M-1:0] r;
    int e;
    c = '0;
    c[0] = 1;
    for (int s = 1; s <= 3; s += 2) begin
      e = s;
      for (int k = 0; k < GF_M; k++) begin
        r = gf_pow(e);
        for (int d = CHK_W; d > 0; d--) c[d] = c[d-1] ^ gf_mul(r, c[d]);
        c[0] = gf_mul(r, c[0]);
        e = (e * 2) % GF_N;
      end
    end
    for (int d = 0; d <= CHK_W; d++) g[d] = c[d][0];
    return g;
  endfunction

  // column p = {alpha^(3p), alpha^p}
  function automatic logic [POS_N*CHK_W-1:0] col_table();
    logic [POS_N*CHK_W-1:0] t;
    logic [GF_M-1:0] a1, a3;
    a1 = 1;
    a3 = 1;
    for (int p = 0; p < POS_N; p++) begin
      t[p*CHK_W +: CHK_W] = {a3, a1};
      a1 = gf_step(a1);
      a3 = gf_step(gf_step(gf_step(a3)));
    end
    return t;
  endfunction

  // polynomial position -> codeword bit index
  function automatic int pos_to_bit(input int p);
    if (p < CHK_W) return DATA_W + p;
    else if (p < POS_N) return p - CHK_W;
    else return POS_N;
  endfunction

  localparam logic [CHK_W:0]             GEN_POLY = gen_poly();
  localparam logic [POS_N*CHK_W-1:0]     COL_TAB  = col_table();
endpackage

// File: rtl/hecc_encoder.sv
module hecc_encoder
  import hecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   code_o
);
  logic [CHK_W-1:0] rem;

  always_comb begin
    rem = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      rem = {rem[CHK_W-2:0], 1'b0} ^ ((data_i[i] ^ rem[CHK_W-1]) ? GEN_POLY[CHK_W-1:0] : '0);
    end
  end

  assign code_o = {^{data_i, rem}, rem, data_i};
endmodule

// File: rtl/hecc_syndrome.sv
module hecc_syndrome
  import hecc_pkg::*;
(
  input  logic [CW_W-1:0]  code_i,
  output logic [CHK_W-1:0] syn_o,
  output logic             par_err_o
);
  logic [POS_N-1:0][CHK_W-1:0] term;

  for (genvar p = 0; p < POS_N; p++) begin : g_term
    localparam int B = pos_to_bit(p);
    assign term[p] = code_i[B] ? COL_TAB[p*CHK_W +: CHK_W] : '0;
  end

  always_comb begin
    syn_o = '0;
    for (int p = 0; p < POS_N; p++) syn_o = syn_o ^ term[p];
  end

  assign par_err_o = ^code_i;
endmodule

// File: rtl/hecc_col_match.sv
module hecc_col_match
  import hecc_pkg::*;
(
  input  logic [CHK_W-1:0] syn_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] pos_o
);
  logic [POS_N-1:0] match;

  for (genvar p = 0; p < POS_N; p++) begin : g_cmp
    assign match[p] = (syn_i == COL_TAB[p*CHK_W +: CHK_W]);
  end

  always_comb begin
    pos_o = '0;
    for (int p = 0; p < POS_N; p++) begin
      if (match[p]) pos_o = pos_o | IDX_W'(p);
    end
  end

  assign hit_o = |match;

  // columns are distinct, so at most one can match
  always_comb assert_unique_col_R2: assert ($onehot0(match));
endmodule

// File: rtl/hecc_codec.sv
module hecc_codec
  import hecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CW_W-1:0]   enc_code_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [CW_W-1:0]   in_code_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [CNT_W-1:0]  out_err_count_o,
  output logic              out_uncorr_o,
  output logic              out_mode2_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CW_W - 1);
  localparam logic [CNT_W-1:0] CNT_BAD  = '1;

  dec_state_e       state_q;
  logic [CW_W-1:0]  cw_q;
  logic [IDX_W-1:0] idx_q, pa_q, pb_q;
  logic             found_q;
  logic [CHK_W-1:0] syn, resid;
  logic             par_err, hit;
  logic [IDX_W-1:0] hit_pos;

  hecc_encoder u_enc (.data_i(enc_data_i), .code_o(enc_code_o));

  hecc_syndrome u_syn (.code_i(cw_q), .syn_o(syn), .par_err_o(par_err));

  // one matcher serves the fast tier and every search step
  always_comb begin
    resid = syn;
    if (state_q == ST_SEARCH && idx_q < IDX_LAST)
      resid = syn ^ COL_TAB[int'(idx_q)*CHK_W +: CHK_W];
  end

  hecc_col_match u_match (.syn_i(resid), .hit_o(hit), .pos_o(hit_pos));

  function automatic logic [DATA_W-1:0] flip_at(input logic [IDX_W-1:0] pos);
    logic [CW_W-1:0] m;
    m = '0;
    if (pos <= IDX_LAST) m[pos_to_bit(int'(pos))] = 1'b1;
    return m[DATA_W-1:0];
  endfunction

  assign in_ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= ST_IDLE;
      cw_q            <= '0;
      idx_q           <= '0;
      pa_q            <= '0;
      pb_q            <= '0;
      found_q         <= 1'b0;
      out_valid_o     <= 1'b0;
      out_data_o      <= '0;
      out_err_count_o <= '0;
      out_uncorr_o    <= 1'b0;
      out_mode2_o     <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid_i) begin
            cw_q    <= in_code_i;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (syn != '0 && !par_err) begin
            // even parity with non-zero syndrome: double error indicated
            state_q <= ST_SEARCH;
            idx_q   <= '0;
            found_q <= 1'b0;
          end else begin
            state_q      <= ST_IDLE;
            out_valid_o  <= 1'b1;
            out_mode2_o  <= 1'b0;
            out_uncorr_o <= 1'b0;
            out_data_o   <= cw_q[DATA_W-1:0];
            if (syn == '0) begin
              out_err_count_o <= par_err ? CNT_W'(1) : CNT_W'(0);
            end else if (hit) begin
              out_data_o      <= cw_q[DATA_W-1:0] ^ flip_at(hit_pos);
              out_err_count_o <= CNT_W'(1);
            end else begin
              out_err_count_o <= CNT_BAD;
              out_uncorr_o    <= 1'b1;
            end
          end
        end
        ST_SEARCH: begin
          idx_q <= idx_q + 1'b1;
          if (!found_q && hit) begin
            found_q <= 1'b1;
            pa_q    <= idx_q;
            pb_q    <= hit_pos;
          end
          if (idx_q == IDX_LAST) begin
            state_q      <= ST_IDLE;
            out_valid_o  <= 1'b1;
            out_mode2_o  <= 1'b1;
            out_uncorr_o <= 1'b0;
            if (found_q) begin
              out_data_o      <= cw_q[DATA_W-1:0] ^ flip_at(pa_q) ^ flip_at(pb_q);
              out_err_count_o <= CNT_W'(2);
            end else if (hit) begin
              out_data_o      <= cw_q[DATA_W-1:0] ^ flip_at(idx_q) ^ flip_at(hit_pos);
              out_err_count_o <= CNT_W'(2);
            end else begin
              out_data_o      <= cw_q[DATA_W-1:0];
              out_err_count_o <= CNT_BAD;
              out_uncorr_o    <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  assert_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_search_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH && idx_q == IDX_LAST) |=> (out_valid_o && out_mode2_o));

  assert_mode2_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_mode2_o && !out_uncorr_o) |-> out_err_count_o == 2'd2);

  assert_uncorr_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_uncorr_o) |-> out_err_count_o == 2'd3);

  assert_fast_tier_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_err_count_o < 2'd2) |-> !out_mode2_o);

  assert_eval_one_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EVAL) |=> (state_q != ST_EVAL));
endmodule

// File: tb/sim_hecc_codec.sv
module sim_hecc_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] enc_data = '0;
  logic [78:0] enc_code;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [78:0] in_code = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [1:0]  out_cnt;
  logic        out_unc, out_m2;

  int unsigned n_chk = 0, n_bad = 0, cyc = 0, n_sent = 0, n_recv = 0;
  logic prev_ov = 1'b0;
  logic done = 1'b0;

  typedef struct packed {
    logic [63:0] data;
    logic [1:0]  cnt;
    logic        unc;
    logic        m2;
    logic [31:0] lat;
    logic [31:0] cap;
    logic [31:0] req;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;  // 250 MHz

  hecc_codec u0 (
    .clk_i(clk), .rst_ni(rst_n), .enc_data_i(enc_data), .enc_code_o(enc_code),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_code_i(in_code),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_err_count_o(out_cnt),
    .out_uncorr_o(out_unc), .out_mode2_o(out_m2));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string rname(input logic [31:0] r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3";
      4: return "R4"; default: return "R6";
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        chk(!prev_ov, "R7 pulse", 64'(prev_ov), 64'd0);
        n_recv++;
        if (q.size() == 0) begin
          chk(1'b0, "R6 unexpected result", 64'(out_data), 64'd0);
        end else begin
          item_t e;
          e = q.pop_front();
          chk(out_data == e.data, {rname(e.req), " data"}, out_data, e.data);
          chk(out_cnt == e.cnt, {rname(e.req), " count"}, 64'(out_cnt), 64'(e.cnt));
          chk(out_unc == e.unc, {rname(e.req), " uncorr"}, 64'(out_unc), 64'(e.unc));
          chk(out_m2 == e.m2, {rname(e.req), " mode2"}, 64'(out_m2), 64'(e.m2));
          chk(cyc - e.cap == e.lat, {rname(e.req), " latency"}, 64'(cyc - e.cap), 64'(e.lat));
          if (e.unc) chk(out_data == e.data, "R5 raw data", out_data, e.data);
        end
      end
      prev_ov <= out_valid;
    end
  end

  task automatic send(input logic [63:0] d, input logic [78:0] flips, input logic [1:0] cnt,
                      input logic unc, input logic m2, input int lat, input int req);
    logic [78:0] cw;
    item_t it;
    enc_data = d;
    #1;
    chk(enc_code[63:0] == d, "R9 data field", enc_code[63:0], d);
    chk(^enc_code == 1'b0, "R9 even weight", 64'(^enc_code), 64'd0);
    cw = enc_code ^ flips;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    it.data = unc ? cw[63:0] : d;
    it.cnt = cnt;
    it.unc = unc;
    it.m2 = m2;
    it.lat = 32'(lat);
    it.cap = cyc + 1;
    it.req = 32'(req);
    q.push_back(it);
    n_sent++;
    in_valid = 1'b1;
    in_code = cw;
    @(negedge clk);
    chk(!in_ready, "R6 ready low after capture", 64'(in_ready), 64'd0);
    in_valid = 1'b0;
  endtask

  function automatic logic [78:0] bitm(input int p);
    logic [78:0] m;
    m = '0;
    m[p] = 1'b1;
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready in reset", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R8 valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready after reset", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R8 valid after reset", 64'(out_valid), 64'd0);

    // R1 clean words
    send(64'h0, '0, 2'd0, 1'b0, 1'b0, 1, 1);
    send('1, '0, 2'd0, 1'b0, 1'b0, 1, 1);
    send(64'hA5A5_0F0F_DEAD_BEEF, '0, 2'd0, 1'b0, 1'b0, 1, 1);
    for (int k = 0; k < 5; k++) send({$urandom, $urandom}, '0, 2'd0, 1'b0, 1'b0, 1, 1);

    // R2 single flip sweep over all 79 bits
    for (int p = 0; p < 79; p++)
      send({$urandom, $urandom}, bitm(p), 2'd1, 1'b0, 1'b0, 1, 2);

    // R3 chosen pairs: parity bit, check/data boundary, check field
    send({$urandom, $urandom}, bitm(77) | bitm(78), 2'd2, 1'b0, 1'b1, 80, 3);
    send({$urandom, $urandom}, bitm(0) | bitm(78), 2'd2, 1'b0, 1'b1, 80, 3);
    send({$urandom, $urandom}, bitm(63) | bitm(64), 2'd2, 1'b0, 1'b1, 80, 3);
    send({$urandom, $urandom}, bitm(64) | bitm(65), 2'd2, 1'b0, 1'b1, 80, 3);
    send({$urandom, $urandom}, bitm(0) | bitm(1), 2'd2, 1'b0, 1'b1, 80, 3);
    for (int k = 0; k < 40; k++) begin
      int a, b;
      a = int'($urandom % 79);
      b = int'($urandom % 79);
      while (b == a) b = int'($urandom % 79);
      send({$urandom, $urandom}, bitm(a) | bitm(b), 2'd2, 1'b0, 1'b1, 80, 3);
    end

    // R4 / R5 triples
    send({$urandom, $urandom}, bitm(0) | bitm(1) | bitm(2), 2'd3, 1'b1, 1'b0, 1, 4);
    send({$urandom, $urandom}, bitm(10) | bitm(70) | bitm(78), 2'd3, 1'b1, 1'b0, 1, 4);
    for (int k = 0; k < 20; k++) begin
      int a, b, c;
      a = int'($urandom % 79);
      b = int'($urandom % 79);
      while (b == a) b = int'($urandom % 79);
      c = int'($urandom % 79);
      while (c == a || c == b) c = int'($urandom % 79);
      send({$urandom, $urandom}, bitm(a) | bitm(b) | bitm(c), 2'd3, 1'b1, 1'b0, 1, 4);
    end

    // R6 junk offered during a search must be ignored
    send(64'h1234_5678_9ABC_DEF0, bitm(5) | bitm(40), 2'd2, 1'b0, 1'b1, 80, 6);
    for (int k = 0; k < 30; k++) begin
      in_valid = 1'b1;
      in_code = {$urandom, $urandom, $urandom};
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_recv == n_sent, "R6 result count", 64'(n_recv), 64'(n_sent));
    send(64'hFEED_FACE_0000_0001, bitm(33), 2'd1, 1'b0, 1'b0, 1, 2);

    repeat (6) @(negedge clk);
    chk(q.size() == 0, "R7 all results seen", 64'(q.size()), 64'd0);
    chk(n_recv == n_sent, "R7 one result per word", 64'(n_recv), 64'(n_sent));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule